// File: doc/BRIEF.md
# Idle-Opportunistic DRAM Refresh Scheduler

This block tells a DRAM controller when to issue a refresh. A counter measures the time since the last completed refresh and raises a mandatory request once a programmable interval has elapsed. Bursts of heavy traffic can therefore never starve refresh, because this request does not depend on the traffic.

The block also watches a per-cycle busy flag from the controller. If idle-triggered refresh is enabled and the command bus has been quiet for a programmed number of consecutive cycles, the refresh is requested early, in a slot where it costs no bandwidth.

Each request stays up until the controller reports that the refresh is done. While a request is outstanding, no second request can start. A completed refresh of either kind restarts the interval and the idle count. A small code output tells the controller which condition raised the request.

Top module: `refresh_sched`

## Requirements
- R1: While reset (`rst_n` low, sampled at the clock edge) is applied, `req_o` is 0 and `req_kind_o` is 2'b00.
- R2: Let E0 be the last edge at which reset was sampled or a done pulse was accepted. If no idle refresh fires, `req_o` rises at edge E0+N, where N = `interval_i`. An interval of 0 behaves as 1.
- R3: The interval request of R2 fires at the same edge when `busy_i` is held high for every cycle, even with idle refresh enabled.
- R4: Let L = `idle_limit_i`. With `idle_en_i` high, `req_o` rises at the edge that ends the (L+1)-th consecutive cycle with `busy_i` low after E0, unless the interval fires first.
- R5: With a limit of 0, the request rises at the edge ending the first idle cycle after E0.
- R6: A cycle with `busy_i` high restarts the idle count, so a full L+1 consecutive idle cycles must follow it.
- R7: With `idle_en_i` low, idle cycles never raise a request; only the interval does.
- R8: Once raised, `req_o` stays high until an edge samples `ack_i` high, and it is low after that edge. A pulse on `ack_i` while no request is pending has no effect: it does not delay the interval request.
- R9: Completing an idle-triggered refresh restarts the interval count, so the next interval request comes N edges after that completion.
- R10: `req_kind_o` is 2'b01 for an interval request and 2'b10 for an idle request. If both conditions hold at the same edge, it reads 2'b01. It is 2'b00 whenever `req_o` is low.
- R11: Idle cycles that fall while a request is pending are not counted toward the next idle refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Controller used the command bus this cycle |
| interval_i | input | CNT_W | Cycles from one refresh completion to the mandatory request |
| idle_limit_i | input | IDLE_W | Consecutive idle cycles needed, minus one |
| idle_en_i | input | 1 | Enables idle-triggered refresh |
| ack_i | input | 1 | Refresh-done pulse from the controller |
| req_o | output | 1 | Refresh request, held until done |
| req_kind_o | output | 2 | 01 = interval, 10 = idle, 00 = none |

## Verification
The bench builds the block with CNT_W = 5 and IDLE_W = 3. This small configuration lets the interval range 0 to 20 and every idle limit 0 to 7 be swept one value at a time, with each rise edge predicted as N or L+1. It also brings the tie cases within reach, where the interval is set to L+1 so that both triggers fire at the same edge. For each limit, the bench places a busy cycle at every position inside the idle window and checks the predicted delay of k+L+2 edges. Further runs check that holding the request pending and pulsing the done input at the wrong time leave the next refresh edge unchanged.

// File: rtl/refresh_sched_pkg.sv
// Shared types for the refresh scheduler.
// Assumes: kind codes are decoded by the controller, so their values are fixed.
package refresh_sched_pkg;

    typedef enum logic [1:0] {
        KIND_NONE     = 2'b00,
        KIND_INTERVAL = 2'b01,
        KIND_IDLE     = 2'b10
    } refresh_kind_e;

endpackage

// File: rtl/rfs_interval_timer.sv
// Counts cycles since the last completed refresh and flags when the
// programmed interval is reached. Assumes clear_i marks a completed refresh,
// and hold_i freezes the count while a request is pending.
// An interval of 0 is treated as 1.
module rfs_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] interval_i,
    output logic             expire_o
);
    localparam int               WIDE_W  = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]  cnt_q;
    logic [WIDE_W-1:0] elapsed_w;

    // Elapsed-cycle counter: restart on completion, freeze while pending, saturate.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (!hold_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry compare, widened so that the +1 cannot wrap.
    always_comb begin
        elapsed_w = {1'b0, cnt_q} + WIDE_W'(1);
        expire_o  = elapsed_w >= {1'b0, interval_i};
    end

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0)) else $error("timer not restarted"); // R9

endmodule

// File: rtl/rfs_idle_detector.sv
// Counts consecutive idle command-bus cycles and flags when the programmed
// limit is met in the current idle cycle. Assumes hold_i is high while a
// request is pending; the count is kept at zero then.
module rfs_idle_detector #(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              hold_i,
    input  logic              en_i,
    input  logic [IDLE_W-1:0] limit_i,
    output logic              hit_o
);
    localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

    logic [IDLE_W-1:0] idle_cnt_q;

    // Consecutive-idle counter: cleared by busy or pending, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || busy_i || hold_i) begin
            idle_cnt_q <= '0;
        end else if (idle_cnt_q != IDLE_MAX) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    // Trigger when this cycle is idle and enough idle cycles preceded it.
    always_comb begin
        hit_o = en_i && !busy_i && (idle_cnt_q >= limit_i);
    end

    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (idle_cnt_q == '0)) else $error("idle count survived busy"); // R6
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (idle_cnt_q == '0)) else $error("idle counted while pending"); // R11

endmodule

// File: rtl/rfs_req_ctrl.sv
// Holds the refresh request and its cause until the done pulse arrives.
// Assumes expire_i and idle_hit_i are combinational trigger flags; the
// interval trigger has priority when both flags are high in one cycle.
module rfs_req_ctrl
    import refresh_sched_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_i,
    input  logic          expire_i,
    input  logic          idle_hit_i,
    output logic          pending_o,
    output logic          ack_take_o,
    output refresh_kind_e kind_o
);
    logic          pend_q;
    refresh_kind_e kind_q;

    // Request state: raise on a trigger, drop on an accepted done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            kind_q <= KIND_NONE;
        end else if (pend_q) begin
            if (ack_i) begin
                pend_q <= 1'b0;
                kind_q <= KIND_NONE;
            end
        end else if (expire_i) begin
            pend_q <= 1'b1;
            kind_q <= KIND_INTERVAL;
        end else if (idle_hit_i) begin
            pend_q <= 1'b1;
            kind_q <= KIND_IDLE;
        end
    end

    // A done pulse counts only while a request is outstanding.
    always_comb begin
        pending_o  = pend_q;
        ack_take_o = pend_q && ack_i;
        kind_o     = kind_q;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !ack_i |=> pend_q) else $error("request dropped early"); // R8
    AST_REQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && ack_i |=> !pend_q) else $error("request not released"); // R8
    AST_KIND_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(kind_q) && (pend_q == (kind_q != KIND_NONE))) else $error("kind mismatch"); // R10
    AST_INTERVAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q && expire_i |=> kind_q == KIND_INTERVAL) else $error("interval lost priority"); // R10

endmodule

// File: rtl/refresh_sched.sv
// Refresh scheduler top: a mandatory interval timer plus an optional
// idle-cycle trigger, feeding one held request with a done handshake.
// Assumes busy_i is valid every cycle and ack_i is a one-cycle pulse.
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [CNT_W-1:0]  interval_i,
    input  logic [IDLE_W-1:0] idle_limit_i,
    input  logic              idle_en_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [1:0]        req_kind_o
);
    logic          expire_w;
    logic          idle_hit_w;
    logic          pending_w;
    logic          ack_take_w;
    refresh_kind_e kind_w;

    rfs_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (ack_take_w),
        .hold_i     (pending_w),
        .interval_i (interval_i),
        .expire_o   (expire_w)
    );

    rfs_idle_detector #(.IDLE_W(IDLE_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy_i),
        .hold_i  (pending_w),
        .en_i    (idle_en_i),
        .limit_i (idle_limit_i),
        .hit_o   (idle_hit_w)
    );

    rfs_req_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_i      (ack_i),
        .expire_i   (expire_w),
        .idle_hit_i (idle_hit_w),
        .pending_o  (pending_w),
        .ack_take_o (ack_take_w),
        .kind_o     (kind_w)
    );

    // Output mapping of the held request and its cause code.
    always_comb begin
        req_o      = pending_w;
        req_kind_o = kind_w;
    end

    AST_IDLE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) && req_kind_o == KIND_IDLE |-> $past(idle_en_i) && !$past(busy_i))
        else $error("idle request without enable or idle cycle"); // R7

endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int PERIOD = 10;
    localparam int CNT_W  = 5;
    localparam int IDLE_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              busy_i = 1'b1;
    logic [CNT_W-1:0]  interval_i = 5'd3;
    logic [IDLE_W-1:0] idle_limit_i = '0;
    logic              idle_en_i = 1'b0;
    logic              ack_i = 1'b0;
    logic              req_o;
    logic [1:0]        req_kind_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    refresh_sched #(.CNT_W(CNT_W), .IDLE_W(IDLE_W)) u_refresh_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .interval_i   (interval_i),
        .idle_limit_i (idle_limit_i),
        .idle_en_i    (idle_en_i),
        .ack_i        (ack_i),
        .req_o        (req_o),
        .req_kind_o   (req_kind_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Accept the pending request, then count edges until the next rise.
    // busy_i is base_busy except in cycle busy_at; ack_i pulses in cycle ack_at.
    task automatic run(input int exp_n, input logic base_busy, input int busy_at,
                       input int ack_at, input logic [1:0] exp_kind, input string tag);
        int got = -1;
        @(negedge clk);
        ack_i  = 1'b1;
        busy_i = base_busy;
        @(posedge clk);
        #1;
        check(req_o == 1'b0, "R8 release", int'(req_o), 0);
        for (int c = 1; c <= 64; c++) begin
            @(negedge clk);
            ack_i  = (c == ack_at);
            busy_i = (c == busy_at) ? ~base_busy : base_busy;
            @(posedge clk);
            #1;
            if (req_o) begin
                got = c;
                break;
            end
        end
        check(got == exp_n, tag, got, exp_n);
        check(req_kind_o == exp_kind, {tag, " kind R10"}, int'(req_kind_o), int'(exp_kind));
    endtask

    initial begin
        int got;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(req_o == 1'b0, "R1 req", int'(req_o), 0);
        check(req_kind_o == 2'b00, "R1 kind", int'(req_kind_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        got = -1;
        for (int c = 1; c <= 20; c++) begin
            @(posedge clk);
            #1;
            if (req_o) begin
                got = c;
                break;
            end
        end
        check(got == 3, "R2 from reset", got, 3);

        // R2/R7: interval sweep, idle refresh off, bus idle
        idle_en_i = 1'b0;
        for (int n = 0; n <= 20; n++) begin
            interval_i = CNT_W'(n);
            run((n == 0) ? 1 : n, 1'b0, 0, 0, 2'b01, "R2 interval sweep R7");
        end

        // R3: constant traffic with idle refresh enabled
        idle_en_i = 1'b1;
        idle_limit_i = '0;
        for (int n = 1; n <= 20; n++) begin
            interval_i = CNT_W'(n);
            run(n, 1'b1, 0, 0, 2'b01, "R3 busy interval");
        end

        // R4/R5: idle limit sweep, long interval
        interval_i = 5'd31;
        for (int l = 0; l <= 7; l++) begin
            idle_limit_i = IDLE_W'(l);
            run(l + 1, 1'b0, 0, 0, 2'b10, (l == 0) ? "R5 limit zero" : "R4 idle limit");
        end

        // R10: interval and idle triggers at the same edge
        for (int l = 0; l <= 7; l++) begin
            idle_limit_i = IDLE_W'(l);
            interval_i = CNT_W'(l + 1);
            run(l + 1, 1'b0, 0, 0, 2'b01, "R10 tie");
        end

        // R6: a busy cycle inside the idle window restarts the count
        interval_i = 5'd31;
        for (int l = 1; l <= 7; l++) begin
            for (int k = 0; k < l; k++) begin
                idle_limit_i = IDLE_W'(l);
                run(k + l + 2, 1'b0, k + 1, 0, 2'b10, "R6 busy break");
            end
        end

        // R9: after an idle refresh the interval restarts from the completion
        idle_limit_i = 3'd3;
        interval_i = 5'd20;
        run(4, 1'b0, 0, 0, 2'b10, "R9 idle first");
        idle_en_i = 1'b0;
        run(20, 1'b0, 0, 0, 2'b01, "R9 interval reload");

        // R8/R11: request held while idle; pending idle cycles not counted
        idle_en_i = 1'b1;
        idle_limit_i = 3'd5;
        interval_i = 5'd31;
        @(negedge clk);
        busy_i = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(posedge clk);
            #1;
            check(req_o == 1'b1, "R8 hold", int'(req_o), 1);
        end
        run(6, 1'b0, 0, 0, 2'b10, "R11 pending idle ignored");

        // R8: done pulse with nothing pending does not disturb the interval
        idle_en_i = 1'b0;
        interval_i = 5'd12;
        run(12, 1'b1, 0, 5, 2'b01, "R8 stray ack");
        run(12, 1'b0, 0, 11, 2'b01, "R8 stray ack late");

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule